// File: doc/BRIEF.md
# Playout Buffer with Data-Request Hysteresis

This block is the sample store between a frame decoder and an audio converter. While decoding is enabled, the decoder writes decoded samples one frame at a time. Each frame is a burst of `FRAME_LEN` samples; the default is 160, which is 20 ms at 8 kHz. The block starts a start-up hold when the first frame arrives. The hold lasts a programmable number of converter sample strobes, and it absorbs jitter in decode time and in frame arrival. After the hold, the block releases one sample for each strobe.

The block tracks how many samples it holds. When that count falls to the low watermark or below, it raises a "data wanted" request to the host. The request then stays unarmed until the occupancy has climbed back to the high watermark. As a result the request fires once per drain cycle and does not chatter. The request shows in a 16-bit status word and can drive an interrupt. Reading the status word clears the request. A hold of 64 strobes (8 ms) is the usual setting.

Top module: `playout_buffer`

## Requirements
- R1: After reset, `fill` is 0, `stat_word` is 0, `irq` is 0 and `out_vld` is 0.
- R2: A frame is `FRAME_LEN` consecutive `in_vld` beats whose first beat has `in_sof` high. An accepted frame raises `fill` by `FRAME_LEN`, and its samples leave in the order they were written.
- R3: No sample is released until `cfg_idd` strobes have been counted after the first accepted frame since enable. The sample is released on the next strobe after those. With `cfg_idd` = 0, the first strobe releases a sample.
- R4: Once released, each `cnv_stb` pulse produces exactly one `out_vld` pulse on the following cycle, carrying the next stored sample, and `fill` drops by one.
- R5: While enabled and armed, the data-wanted flag (status bit 8) is set one cycle after `fill` is less than or equal to `cfg_lo`.
- R6: Once the flag has been set, it cannot be set again until `fill` has reached at least `cfg_hi`. Reset and enable leave the flag armed.
- R7: `irq` is high exactly when the data-wanted flag is set and `irq_en` is high.
- R8: A `stat_rd` pulse clears the data-wanted flag and `irq` on the next cycle.
- R9: A strobe after the hold that finds the buffer empty produces an `out_vld` pulse with data 0 and sets the sticky underflow bit (status bit 0).
- R10: A frame whose first beat finds `fill + FRAME_LEN > DEPTH` is dropped whole and sets the sticky overflow bit (status bit 1). `fill` does not grow.
- R11: While `dec_en` is low, the buffer is emptied, all status bits are cleared, writes and strobes are ignored, and the start-up hold is re-armed for the next first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_en | input | 1 | Decoding enabled; low flushes and re-arms |
| cfg_idd | input | IW | Start-up hold length in strobes |
| cfg_lo | input | OW | Low watermark in samples |
| cfg_hi | input | OW | High watermark (re-arm level) in samples |
| irq_en | input | 1 | Interrupt enable |
| in_vld | input | 1 | Decoded sample valid |
| in_sof | input | 1 | First sample of a frame |
| in_data | input | SW | Decoded sample |
| cnv_stb | input | 1 | Converter sample-rate strobe, one cycle |
| out_vld | output | 1 | Sample to the converter valid, one cycle |
| out_data | output | SW | Sample to the converter |
| stat_rd | input | 1 | Status word read pulse |
| stat_word | output | 16 | Status: bit 8 data wanted, bit 1 overflow, bit 0 underflow |
| irq | output | 1 | Interrupt request |
| fill | output | OW | Samples held |

## Verification
The hardest state to reach from the ports is a second crossing of the low watermark while the flag is unarmed, because the flag is armed again only after the occupancy has come back up to the high watermark. The bench first clears the flag that appears at enable. It then fills a frame past the high watermark and drains it with strobes to exactly the low watermark, checking the cycle before and the cycle after. It then clears the flag again and drains to empty, checking that the flag stays low. A drop caused by overflow is reached by writing three frames with no strobes and then a fourth frame. The bench then drains 480 samples, which shows the fourth frame never entered the buffer.

// File: rtl/pb_pkg.sv
package pb_pkg;
   typedef enum logic [1:0] {
      PB_IDLE = 2'd0,
      PB_HOLD = 2'd1,
      PB_PLAY = 2'd2
   } pb_state_e;

   localparam int ST_UDF_BIT = 0;
   localparam int ST_OVF_BIT = 1;
   localparam int ST_DW_BIT  = 8;
endpackage

// File: rtl/pb_store.sv
module pb_store #(
   parameter int SW        = 16,
   parameter int DEPTH     = 512,
   parameter int FRAME_LEN = 160,
   localparam int OW = $clog2(DEPTH + 1),
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          wr_vld,
   input  logic          wr_sof,
   input  logic [SW-1:0] wr_data,
   input  logic          rd_en,
   output logic [SW-1:0] rd_data,
   output logic [OW-1:0] occ,
   output logic          sof_take,
   output logic          drop_evt
);
   logic [SW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic [OW:0]   need;
   logic          fits, keep_q, push, pop;

   assign need     = {1'b0, occ} + (OW+1)'(FRAME_LEN);
   assign fits     = need <= (OW+1)'(DEPTH);
   assign sof_take = en && wr_vld && wr_sof && fits;
   assign drop_evt = en && wr_vld && wr_sof && !fits;
   assign push     = en && wr_vld && (wr_sof ? fits : keep_q);
   assign pop      = en && rd_en && (occ != '0);
   assign rd_data  = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wp_nxt = wp + 1'b1;
         assign rp_nxt = rp + 1'b1;
      end else begin : g_cmp_wrap
         assign wp_nxt = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nxt = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp     <= '0;
         rp     <= '0;
         occ    <= '0;
         keep_q <= 1'b0;
      end else if (!en) begin
         wp     <= '0;
         rp     <= '0;
         occ    <= '0;
         keep_q <= 1'b0;
      end else begin
         if (wr_vld && wr_sof) keep_q <= fits;
         if (push) wp <= wp_nxt;
         if (pop)  rp <= rp_nxt;
         occ <= occ + OW'(push) - OW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wr_data;
   end

   // R2
   occ_le_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OW'(DEPTH));

   // R10
   drop_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && wr_vld && wr_sof && (({1'b0, occ} + (OW+1)'(FRAME_LEN)) > (OW+1)'(DEPTH)))
      |=> occ <= $past(occ));
endmodule

// File: rtl/pb_hold.sv
module pb_hold import pb_pkg::*; #(
   parameter int IW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          first_frame,
   input  logic          stb,
   input  logic [IW-1:0] idd,
   input  logic          empty,
   output logic          pop,
   output logic          starve
);
   pb_state_e     st;
   logic [IW-1:0] dly;
   logic          play_now;

   assign play_now = (st == PB_PLAY) || ((st == PB_HOLD) && (dly >= idd));
   assign pop      = en && stb && play_now && !empty;
   assign starve   = en && stb && play_now && empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PB_IDLE;
         dly <= '0;
      end else if (!en) begin
         st  <= PB_IDLE;
         dly <= '0;
      end else begin
         unique case (st)
            PB_IDLE: if (first_frame) begin
               st  <= PB_HOLD;
               dly <= '0;
            end
            PB_HOLD: if (stb) begin
               if (dly >= idd) st <= PB_PLAY;
               else            dly <= dly + 1'b1;
            end
            default: ;
         endcase
      end
   end

   // R4
   pop_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop || starve) |-> (stb && st != PB_IDLE));

   // R3
   play_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PB_PLAY && $past(st) == PB_HOLD) |-> $past(stb));
endmodule

// File: rtl/pb_watermark.sv
module pb_watermark #(
   parameter int OW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [OW-1:0] occ,
   input  logic [OW-1:0] lo,
   input  logic [OW-1:0] hi,
   input  logic          irq_en,
   input  logic          clr,
   output logic          flag,
   output logic          irq
);
   logic armed, set;

   assign set = en && armed && (occ <= lo);
   assign irq = flag && irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b1;
      end else if (!en) begin
         flag  <= 1'b0;
         armed <= 1'b1;
      end else if (set) begin
         flag  <= 1'b1;
         armed <= 1'b0;
      end else begin
         if (clr)       flag  <= 1'b0;
         if (occ >= hi) armed <= 1'b1;
      end
   end

   // R5
   dw_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(occ) <= $past(lo)));

   // R6
   dw_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(armed));
endmodule

// File: rtl/playout_buffer.sv
module playout_buffer import pb_pkg::*; #(
   parameter int SW        = 16,
   parameter int DEPTH     = 512,
   parameter int FRAME_LEN = 160,
   parameter int IW        = 16,
   localparam int OW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec_en,
   input  logic [IW-1:0] cfg_idd,
   input  logic [OW-1:0] cfg_lo,
   input  logic [OW-1:0] cfg_hi,
   input  logic          irq_en,
   input  logic          in_vld,
   input  logic          in_sof,
   input  logic [SW-1:0] in_data,
   input  logic          cnv_stb,
   output logic          out_vld,
   output logic [SW-1:0] out_data,
   input  logic          stat_rd,
   output logic [15:0]   stat_word,
   output logic          irq,
   output logic [OW-1:0] fill
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("playout_buffer: DEPTH must be at least 2");
      end
      if (FRAME_LEN < 1 || FRAME_LEN > DEPTH) begin : g_bad_frame
         $error("playout_buffer: FRAME_LEN must lie in 1..DEPTH");
      end
      if (SW < 1) begin : g_bad_sw
         $error("playout_buffer: SW must be positive");
      end
   endgenerate

   logic [SW-1:0] rd_data;
   logic          sof_take, drop_evt, pop, starve, dw_flag;
   logic          udf_q, ovf_q;

   pb_store #(.SW(SW), .DEPTH(DEPTH), .FRAME_LEN(FRAME_LEN)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (dec_en),
      .wr_vld   (in_vld),
      .wr_sof   (in_sof),
      .wr_data  (in_data),
      .rd_en    (pop),
      .rd_data  (rd_data),
      .occ      (fill),
      .sof_take (sof_take),
      .drop_evt (drop_evt)
   );

   pb_hold #(.IW(IW)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (dec_en),
      .first_frame (sof_take),
      .stb         (cnv_stb),
      .idd         (cfg_idd),
      .empty       (fill == '0),
      .pop         (pop),
      .starve      (starve)
   );

   pb_watermark #(.OW(OW)) u_wm (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (dec_en),
      .occ    (fill),
      .lo     (cfg_lo),
      .hi     (cfg_hi),
      .irq_en (irq_en),
      .clr    (stat_rd),
      .flag   (dw_flag),
      .irq    (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_data <= '0;
         udf_q    <= 1'b0;
         ovf_q    <= 1'b0;
      end else if (!dec_en) begin
         out_vld  <= 1'b0;
         out_data <= '0;
         udf_q    <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         out_vld <= pop || starve;
         if (pop)         out_data <= rd_data;
         else if (starve) out_data <= '0;
         if (starve)   udf_q <= 1'b1;
         if (drop_evt) ovf_q <= 1'b1;
      end
   end

   always_comb begin
      stat_word             = '0;
      stat_word[ST_UDF_BIT] = udf_q;
      stat_word[ST_OVF_BIT] = ovf_q;
      stat_word[ST_DW_BIT]  = dw_flag;
   end

   // R11
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_en |=> (fill == '0 && !out_vld));

   // R9
   starve_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_en && starve) |=> (out_vld && out_data == '0 && udf_q));
endmodule

// File: tb/tb_playout_buffer.sv
module tb_playout_buffer;
   localparam int SW = 16, DEPTH = 512, FL = 160, IW = 16;
   localparam int OW = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dec_en = 1'b0, irq_en = 1'b0;
   logic [IW-1:0] cfg_idd = '0;
   logic [OW-1:0] cfg_lo = '0, cfg_hi = '0;
   logic          in_vld = 1'b0, in_sof = 1'b0, cnv_stb = 1'b0, stat_rd = 1'b0;
   logic [SW-1:0] in_data = '0;
   logic          out_vld, irq;
   logic [SW-1:0] out_data;
   logic [15:0]   stat_word;
   logic [OW-1:0] fill;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   playout_buffer #(.SW(SW), .DEPTH(DEPTH), .FRAME_LEN(FL), .IW(IW)) dut (
      .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .cfg_idd(cfg_idd),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .irq_en(irq_en), .in_vld(in_vld),
      .in_sof(in_sof), .in_data(in_data), .cnv_stb(cnv_stb), .out_vld(out_vld),
      .out_data(out_data), .stat_rd(stat_rd), .stat_word(stat_word), .irq(irq),
      .fill(fill)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_frame(input int base);
      for (int i = 0; i < FL; i++) begin
         in_vld = 1'b1; in_sof = (i == 0); in_data = SW'(base + i);
         @(negedge clk);
      end
      in_vld = 1'b0; in_sof = 1'b0;
   endtask

   task automatic strobe();
      cnv_stb = 1'b1;
      @(negedge clk);
      cnv_stb = 1'b0;
   endtask

   task automatic read_stat();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 fill", int'(fill), 0);
      chk("R1 status", int'(stat_word), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 out_vld", int'(out_vld), 0);
   endtask

   task automatic t_enable_clear();
      cfg_lo = 40; cfg_hi = 150; irq_en = 1'b1; cfg_idd = 4;
      dec_en = 1'b1;
      @(negedge clk);
      chk("R5 flag at enable", int'(stat_word[8]), 1);
      chk("R7 irq with enable", int'(irq), 1);
      read_stat();
      chk("R8 flag cleared", int'(stat_word[8]), 0);
      chk("R8 irq cleared", int'(irq), 0);
      idle(3);
      chk("R6 no reset while unarmed", int'(stat_word[8]), 0);
   endtask

   task automatic t_play_drain();
      int got_bad;
      write_frame(100);
      chk("R2 fill after frame", int'(fill), FL);
      got_bad = 0;
      for (int i = 0; i < 4; i++) begin
         strobe();
         if (out_vld) got_bad++;
      end
      chk("R3 no output during hold", got_bad, 0);
      strobe();
      chk("R3 first release", int'(out_vld), 1);
      chk("R3 first sample", int'(out_data), 100);
      got_bad = 0;
      for (int k = 1; k < 119; k++) begin
         strobe();
         if (!out_vld || out_data != SW'(100 + k)) got_bad++;
      end
      chk("R4 ordered samples", got_bad, 0);
      idle(1);
      chk("R4 fill after 119", int'(fill), 41);
      chk("R5 flag above low", int'(stat_word[8]), 0);
      strobe();
      chk("R4 sample 119", int'(out_data), 219);
      idle(1);
      chk("R5 flag at low", int'(stat_word[8]), 1);
      chk("R7 irq at low", int'(irq), 1);
      read_stat();
      chk("R8 clear after drain", int'(stat_word[8]), 0);
      got_bad = 0;
      for (int k = 120; k < FL; k++) begin
         strobe();
         if (!out_vld || out_data != SW'(100 + k)) got_bad++;
      end
      chk("R4 tail samples", got_bad, 0);
      idle(2);
      chk("R6 no flag below low", int'(stat_word[8]), 0);
      chk("R4 empty", int'(fill), 0);
      strobe();
      chk("R9 starve vld", int'(out_vld), 1);
      chk("R9 starve data", int'(out_data), 0);
      chk("R9 underflow bit", int'(stat_word[0]), 1);
   endtask

   task automatic t_overflow();
      int got_bad;
      dec_en = 1'b0;
      @(negedge clk);
      chk("R11 flush fill", int'(fill), 0);
      chk("R11 flush status", int'(stat_word), 0);
      write_frame(500);
      strobe();
      chk("R11 writes ignored", int'(fill), 0);
      chk("R11 strobe ignored", int'(out_vld), 0);
      irq_en = 1'b0; cfg_idd = 0;
      dec_en = 1'b1;
      @(negedge clk);
      chk("R7 flag no irq", int'(stat_word[8]), 1);
      chk("R7 irq masked", int'(irq), 0);
      read_stat();
      write_frame(1000);
      write_frame(2000);
      write_frame(3000);
      chk("R2 three frames", int'(fill), 3 * FL);
      write_frame(4000);
      chk("R10 fill unchanged", int'(fill), 3 * FL);
      chk("R10 overflow bit", int'(stat_word[1]), 1);
      strobe();
      chk("R3 zero hold vld", int'(out_vld), 1);
      chk("R3 zero hold data", int'(out_data), 1000);
      got_bad = 0;
      for (int j = 1; j < 3 * FL; j++) begin
         strobe();
         if (!out_vld || out_data != SW'((j / FL + 1) * 1000 + j % FL)) got_bad++;
      end
      chk("R10 dropped frame absent", got_bad, 0);
      chk("R10 drained", int'(fill), 0);
   endtask

   task automatic t_default_hold();
      int got_bad;
      dec_en = 1'b0;
      @(negedge clk);
      cfg_idd = 64; irq_en = 1'b1;
      dec_en = 1'b1;
      @(negedge clk);
      got_bad = 0;
      for (int i = 0; i < 10; i++) begin
         strobe();
         if (out_vld) got_bad++;
      end
      chk("R11 hold re-armed", got_bad, 0);
      write_frame(7000);
      got_bad = 0;
      for (int i = 0; i < 64; i++) begin
         strobe();
         if (out_vld) got_bad++;
      end
      chk("R3 64-strobe hold", got_bad, 0);
      chk("R3 fill held", int'(fill), FL);
      strobe();
      chk("R3 release after 64", int'(out_data), 7000);
      strobe();
      chk("R4 next after hold", int'(out_data), 7001);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_clear();
      t_play_drain();
      t_overflow();
      t_default_hold();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule